// File: doc/BRIEF.md
# Lockable Watchdog Reset Timer

This block is a watchdog down-counter that a power-management domain uses to force a system reset. It counts on a slow time-base tick: one enable pulse per period of a 32.768 kHz clock. The host reaches it through a simple 16-bit register write/read port. The control register and the two reload-value halves sit behind a write lock, which opens only when a 16-bit magic key is written to the lock register.

The host programs the block in this order:
1. Unlock the block.
2. Select new-load mode.
3. Write the upper reload half, then the lower half. The write to the lower half copies the full 32-bit reload value into the counter.
4. Set run and reset-enable.
5. Lock the block again by writing any value other than the key.

For example, a 50 ms timeout is a reload value of 1638 with zero in the upper half.

The counter only moves when three bits are set: the run bit, a module-enable bit and a clock-enable bit. When the counter expires, it reloads. If reset-enable is set, the block also drives a reset pulse that lasts a fixed number of ticks. If reset-enable is clear, the block instead sets a sticky expired flag that the host can read.

Top module: `wdog_timer`

## Requirements
- R1: After reset the block is locked, the control, reload, enable and counter values read as zero, and `wdg_rst_o` is low.
- R2: Writing 0xE551 to offset 0x0A0 unlocks the block. Writing any other value to that offset locks it. Bit 0 of a read at 0x0A0 is 1 while the block is locked.
- R3: While the block is locked, writes to the control register (0x088), load-low (0x080) and load-high (0x084) are ignored. Reads at those offsets still return the stored values.
- R4: A write to load-low while control bit 2 (new-load) is set loads {load-high, written value} into the counter in the same cycle. With bit 2 clear, the write only updates the stored low half and leaves the counter unchanged.
- R5: The counter decrements by one on each tick only when three bits are all set: control bit 1 (run), bit 2 of the module-enable register at 0x08C, and bit 2 of the clock-enable register at 0x090.
- R6: With the run bit clear, the counter holds its value across ticks.
- R7: A tick that takes the counter from 1 to 0 is an expiry. On expiry the counter reloads from {load-high, load-low}. If control bit 3 (reset-enable) is set, `wdg_rst_o` rises on the next clock and stays high for exactly 4 tick periods.
- R8: An expiry with reset-enable clear leaves `wdg_rst_o` low and sets a sticky flag read at control bit 4. The flag stays set until the host writes 1 to bit 4 while the block is unlocked.
- R9: The current counter reads back at 0x098 (bits 15:0) and at 0x09C (bits 31:16).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle pulse per 32.768 kHz period |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 12 | Register offset for reads and writes |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| wdg_rst_o | output | 1 | System reset pulse |

## Verification
A wrong lock state shows up at the next read of the control or reload registers: a write the host expected to be dropped shows as a changed value, or an accepted write shows as an unchanged one. A wrong counter value or enable decode shows at the next counter read after one tick, or as an expiry a tick too early or too late. Expiry handling is watched at `wdg_rst_o` and control bit 4 from the clock after the expiring tick. The pulse length is checked tick by tick until it falls.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 16;
    localparam int CNT_W  = 2 * DATA_W;

    localparam logic [ADDR_W-1:0] OFS_LOAD_LO = 12'h080;
    localparam logic [ADDR_W-1:0] OFS_LOAD_HI = 12'h084;
    localparam logic [ADDR_W-1:0] OFS_CTRL    = 12'h088;
    localparam logic [ADDR_W-1:0] OFS_MOD_EN  = 12'h08C;
    localparam logic [ADDR_W-1:0] OFS_CLK_EN  = 12'h090;
    localparam logic [ADDR_W-1:0] OFS_CNT_LO  = 12'h098;
    localparam logic [ADDR_W-1:0] OFS_CNT_HI  = 12'h09C;
    localparam logic [ADDR_W-1:0] OFS_LOCK    = 12'h0A0;

    localparam int BIT_RUN   = 1;
    localparam int BIT_NEWLD = 2;
    localparam int BIT_RSTEN = 3;
    localparam int BIT_EXP   = 4;
    localparam int BIT_EN    = 2;

    typedef struct packed {
        logic run;
        logic newld;
        logic rsten;
        logic expired;
    } ctrl_t;
endpackage

// File: rtl/wdog_lock.sv
module wdog_lock
    import wdog_pkg::*;
#(
    parameter logic [DATA_W-1:0] KEY = 16'hE551
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic              sel_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              locked_o
);
    typedef struct packed {
        logic locked;
    } lock_st_t;

    lock_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i && sel_i) begin
            st_d.locked = (wdata_i != KEY);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.locked <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign locked_o = st_q.locked;
endmodule

// File: rtl/wdog_regfile.sv
module wdog_regfile
    import wdog_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              locked_i,
    input  logic              expire_i,
    output ctrl_t             ctrl_o,
    output logic [DATA_W-1:0] lo_o,
    output logic [DATA_W-1:0] hi_o,
    output logic              mod_en_o,
    output logic              clk_en_o,
    output logic              load_o
);
    typedef struct packed {
        ctrl_t             ctrl;
        logic [DATA_W-1:0] lo;
        logic [DATA_W-1:0] hi;
        logic              mod_en;
        logic              clk_en;
    } reg_st_t;

    reg_st_t st_d, st_q;
    logic    wr_open;

    always_comb begin
        st_d    = st_q;
        wr_open = wr_i && !locked_i;
        load_o  = 1'b0;
        if (wr_open && addr_i == OFS_CTRL) begin
            st_d.ctrl.run   = wdata_i[BIT_RUN];
            st_d.ctrl.newld = wdata_i[BIT_NEWLD];
            st_d.ctrl.rsten = wdata_i[BIT_RSTEN];
            if (wdata_i[BIT_EXP]) begin
                st_d.ctrl.expired = 1'b0;
            end
        end
        if (wr_open && addr_i == OFS_LOAD_HI) begin
            st_d.hi = wdata_i;
        end
        if (wr_open && addr_i == OFS_LOAD_LO) begin
            st_d.lo = wdata_i;
            load_o  = st_q.ctrl.newld;
        end
        if (wr_i && addr_i == OFS_MOD_EN) begin
            st_d.mod_en = wdata_i[BIT_EN];
        end
        if (wr_i && addr_i == OFS_CLK_EN) begin
            st_d.clk_en = wdata_i[BIT_EN];
        end
        if (expire_i && !st_q.ctrl.rsten) begin
            st_d.ctrl.expired = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_o   = st_q.ctrl;
    assign lo_o     = st_q.lo;
    assign hi_o     = st_q.hi;
    assign mod_en_o = st_q.mod_en;
    assign clk_en_o = st_q.clk_en;
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             active_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic [CNT_W-1:0] count_o,
    output logic             expire_o
);
    typedef struct packed {
        logic [CNT_W-1:0] count;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        expire_o = 1'b0;
        if (load_i) begin
            st_d.count = load_val_i;
        end else if (tick_i && active_i && st_q.count != '0) begin
            if (st_q.count == CNT_W'(1)) begin
                st_d.count = reload_i;
                expire_o   = 1'b1;
            end else begin
                st_d.count = st_q.count - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o = st_q.count;
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
    parameter int TICKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic fire_i,
    output logic rst_o
);
    localparam int PW = $clog2(TICKS + 1);

    typedef struct packed {
        logic [PW-1:0] left;
    } pulse_st_t;

    pulse_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fire_i) begin
            st_d.left = PW'(TICKS);
        end else if (tick_i && st_q.left != '0) begin
            st_d.left = st_q.left - PW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rst_o = (st_q.left != '0);
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdog_pkg::*;
#(
    parameter logic [15:0] KEY       = 16'hE551,
    parameter int          RST_TICKS = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        bus_wr,
    input  logic [11:0] bus_addr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    output logic        wdg_rst_o
);
    logic              locked;
    ctrl_t             ctrl;
    logic [DATA_W-1:0] lo_val;
    logic [DATA_W-1:0] hi_val;
    logic              mod_en;
    logic              clk_en;
    logic              cnt_load;
    logic [CNT_W-1:0]  count;
    logic              expire;
    logic              fire;
    logic              ctrl_run;
    logic              active;

    wdog_lock #(.KEY(KEY)) lock_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (bus_wr),
        .sel_i    (bus_addr == OFS_LOCK),
        .wdata_i  (bus_wdata),
        .locked_o (locked)
    );

    wdog_regfile regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (bus_wr),
        .addr_i   (bus_addr),
        .wdata_i  (bus_wdata),
        .locked_i (locked),
        .expire_i (expire),
        .ctrl_o   (ctrl),
        .lo_o     (lo_val),
        .hi_o     (hi_val),
        .mod_en_o (mod_en),
        .clk_en_o (clk_en),
        .load_o   (cnt_load)
    );

    assign ctrl_run = ctrl.run;
    assign active   = ctrl.run && mod_en && clk_en;
    assign fire     = expire && ctrl.rsten;

    wdog_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .active_i   (active),
        .load_i     (cnt_load),
        .load_val_i ({hi_val, bus_wdata}),
        .reload_i   ({hi_val, lo_val}),
        .count_o    (count),
        .expire_o   (expire)
    );

    wdog_pulse #(.TICKS(RST_TICKS)) pulse_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick),
        .fire_i (fire),
        .rst_o  (wdg_rst_o)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_LOAD_LO: bus_rdata = lo_val;
            OFS_LOAD_HI: bus_rdata = hi_val;
            OFS_CTRL: begin
                bus_rdata[BIT_RUN]   = ctrl.run;
                bus_rdata[BIT_NEWLD] = ctrl.newld;
                bus_rdata[BIT_RSTEN] = ctrl.rsten;
                bus_rdata[BIT_EXP]   = ctrl.expired;
            end
            OFS_MOD_EN:  bus_rdata[BIT_EN] = mod_en;
            OFS_CLK_EN:  bus_rdata[BIT_EN] = clk_en;
            OFS_CNT_LO:  bus_rdata = count[DATA_W-1:0];
            OFS_CNT_HI:  bus_rdata = count[CNT_W-1:DATA_W];
            OFS_LOCK:    bus_rdata[0] = locked;
            default:     bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk
    import wdog_pkg::*;
#(
    parameter logic [15:0] KEY = 16'hE551
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic [11:0]      bus_addr,
    input logic [15:0]      bus_wdata,
    input logic             locked,
    input logic             ctrl_run,
    input logic             cnt_load,
    input logic [CNT_W-1:0] count,
    input logic             fire,
    input logic             wdg_rst_o
);
    assert_unlock_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_LOCK && bus_wdata == KEY) |=> !locked);

    assert_relock_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_LOCK && bus_wdata != KEY) |=> locked);

    assert_locked_ctrl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && bus_wr && bus_addr == OFS_CTRL) |=> $stable(ctrl_run));

    assert_locked_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && bus_wr && bus_addr == OFS_LOAD_LO) |-> !cnt_load);

    assert_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_run && !cnt_load) |=> $stable(count));

    assert_pulse_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> wdg_rst_o);

    assert_pulse_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdg_rst_o) |-> $past(fire));
endmodule

bind wdog_timer wdog_timer_chk #(.KEY(KEY)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .locked    (locked),
    .ctrl_run  (ctrl_run),
    .cnt_load  (cnt_load),
    .count     (count),
    .fire      (fire),
    .wdg_rst_o (wdg_rst_o)
);

// File: tb/wdog_timer_tb_top.sv
module wdog_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        wdg_rst_o;

    typedef struct {
        logic        pin;
        logic [15:0] exp;
        string       tag;
    } item_t;

    item_t exp_q[$];
    event  mon_ev;
    int    checks = 0;
    int    errors = 0;
    bit    done = 0;

    always #10 clk = ~clk;

    wdog_timer dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .wdg_rst_o (wdg_rst_o)
    );

    // monitor: pops expected items and compares against the ports
    initial begin
        forever begin
            @(mon_ev);
            while (exp_q.size() > 0) begin
                item_t it;
                logic [15:0] act;
                it  = exp_q.pop_front();
                act = it.pin ? {15'b0, wdg_rst_o} : bus_rdata;
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s: actual 0x%04h expected 0x%04h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [11:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [15:0] e, input string tag);
        item_t it;
        @(negedge clk);
        bus_addr = a;
        #2;
        it.pin = 1'b0; it.exp = e; it.tag = tag;
        exp_q.push_back(it);
        -> mon_ev;
    endtask

    task automatic pin(input logic e, input string tag);
        item_t it;
        @(negedge clk);
        #2;
        it.pin = 1'b1; it.exp = {15'b0, e}; it.tag = tag;
        exp_q.push_back(it);
        -> mon_ev;
    endtask

    task automatic do_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(12'h0A0, 16'h0001, "R1 locked after reset");
        rd(12'h088, 16'h0000, "R1 ctrl after reset");
        rd(12'h098, 16'h0000, "R1 count after reset");
        pin(1'b0, "R1 reset pin low");
        // R3 locked writes ignored
        wr(12'h088, 16'h000E);
        rd(12'h088, 16'h0000, "R3 ctrl write while locked");
        wr(12'h084, 16'h0005);
        rd(12'h084, 16'h0000, "R3 load-high write while locked");
        // R2 unlock
        wr(12'h0A0, 16'hE551);
        rd(12'h0A0, 16'h0000, "R2 unlocked by key");
        // R4 new-load transfer, R9 count readback
        wr(12'h088, 16'h0004);
        wr(12'h084, 16'h0000);
        wr(12'h080, 16'h0003);
        rd(12'h098, 16'h0003, "R4 R9 count low after new-load");
        rd(12'h09C, 16'h0000, "R9 count high");
        wr(12'h088, 16'h0000);
        wr(12'h080, 16'h0009);
        rd(12'h098, 16'h0003, "R4 no transfer without new-load");
        rd(12'h080, 16'h0009, "R4 load-low stored");
        wr(12'h088, 16'h0004);
        wr(12'h080, 16'h0003);
        // R5 enable gating
        wr(12'h088, 16'h0006);
        do_tick();
        rd(12'h098, 16'h0003, "R5 no count without module enable");
        wr(12'h08C, 16'h0004);
        do_tick();
        rd(12'h098, 16'h0003, "R5 no count without clock enable");
        wr(12'h090, 16'h0004);
        do_tick();
        rd(12'h098, 16'h0002, "R5 counts with all enables");
        // R6 freeze
        wr(12'h088, 16'h0004);
        do_tick();
        do_tick();
        rd(12'h098, 16'h0002, "R6 frozen with run clear");
        // R2 relock with inverse key, R3 ignored
        wr(12'h0A0, 16'h1AAE);
        rd(12'h0A0, 16'h0001, "R2 relocked");
        wr(12'h088, 16'h000E);
        rd(12'h088, 16'h0004, "R3 ctrl unchanged while locked");
        // R8 expiry without reset enable
        wr(12'h0A0, 16'hE551);
        wr(12'h088, 16'h0006);
        do_tick();
        do_tick();
        rd(12'h098, 16'h0003, "R7 counter reloaded on expiry");
        rd(12'h088, 16'h0016, "R8 expired flag set");
        pin(1'b0, "R8 no reset pulse");
        do_tick();
        rd(12'h088, 16'h0016, "R8 flag sticky");
        wr(12'h088, 16'h0016);
        rd(12'h088, 16'h0006, "R8 flag cleared");
        // R7 reset pulse: count is 2
        wr(12'h088, 16'h000E);
        do_tick();
        pin(1'b0, "R7 no pulse before expiry");
        do_tick();
        pin(1'b1, "R7 pulse after expiry");
        rd(12'h088, 16'h000E, "R7 no flag with reset enable");
        wr(12'h088, 16'h0008);
        for (int i = 1; i <= 4; i++) begin
            do_tick();
            pin(i < 4, "R7 pulse length");
        end
        rd(12'h098, 16'h0003, "R6 R7 reloaded and frozen");
        @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule